// File: doc/BRIEF.md
# Load-Adaptive PWM Frequency Controller

This block produces the gate-enable pulse train for a peak-current-mode converter. The switching rate follows a digitised feedback code given in millivolts. At heavy load the rate sits at a fixed maximum. Over a band of feedback codes it falls linearly in frequency. Below that band it holds a low floor. When feedback drops far enough, whole periods are skipped (burst), with hysteresis between the enter and exit levels. A slow triangular dither moves the frequency around its operating point to spread the emission spectrum. Each on-pulse ends at the maximum duty limit or at a current-sense trip that arrives after the leading-edge blanking window.

Frequency is produced by a phase accumulator, so a frequency that is linear in feedback is simply a step size that is linear in feedback. The step size, the burst decision and the dither are all taken up only when the accumulator wraps. This means a period never changes length, and a pulse is never cut short, by a control update. All times and frequencies are parameters converted to cycle counts and step sizes against `CLK_HZ`. Here W is `ACC_W`, the accumulator width, and the default clock is 100 MHz.

Top module: `lf_pwm_ctrl`

## Requirements
- R1: For feedback at or above 2700 mV the base step is floor(65000·2^W/CLK_HZ), which is 65 kHz, and the dither depth is floor(4000·2^W/CLK_HZ).
- R2: For feedback at or below 2250 mV the base step is floor(24000·2^W/CLK_HZ), which is 24 kHz, and the dither depth is floor(1550·2^W/CLK_HZ).
- R3: For feedback strictly between 2250 and 2700 mV, with d = feedback−2250, the base step is lo + floor(d·Sb/2^12), where Sb = floor((hi−lo)·2^12/450). The dither depth follows the same law with its own slope Sh.
- R4: The burst flag is 0 after reset. It is set the cycle after feedback is below 2000 mV and cleared the cycle after feedback is above 2100 mV. Otherwise it holds, so the codes 2000 to 2100 inclusive change nothing.
- R5: Each period latches the burst flag at its start. In a latched-burst period the gate stays low for the whole period.
- R6: The dither position t is signed, starts at 0 and rises first. It moves by 1 every P/(4·2^TRI_BITS) cycles, where P is the dither period in cycles, and reverses on reaching ±2^TRI_BITS. The applied step is base + floor(depth·t/2^TRI_BITS), using t as it stands in the cycle the step is taken.
- R7: Within a period the gate is high only while the phase is below floor(2^W·85/100).
- R8: A current-sense trip is ignored while the position within the period is below the blanking count floor(270 ns·CLK_HZ).
- R9: A trip at or after the blanking count forces the gate low from the next cycle until the next period starts.
- R10: The phase grows by the latched step every enabled cycle. A period ends in the cycle where phase+step ≥ 2^W. The step and the burst latch are reloaded only then, or in the first enabled cycle.
- R11: During reset and while enable is low, the gate is low and the phase, position and trip latch are cleared. The first enabled cycle starts at phase 0.
- R12: The period output holds the cycle count of the last completed period and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| fb_mv_i | input | FB_W | Feedback level in millivolts |
| cs_trip_i | input | 1 | Resolved current-sense trip |
| gate_o | output | 1 | Gate enable pulse |
| burst_o | output | 1 | Burst (skip) state |
| period_o | output | ACC_W | Length in cycles of the last completed period |

## Verification
The assertions rely on the largest step, base plus dither, being less than 15 % of the accumulator range. Under that condition the phase is always past the duty threshold in the last cycle of a period. The stimulus respects this by keeping both frequencies far below the clock. The assertions also take the feedback code and the trip flag to be clean, synchronous, single-cycle-valid values. The bench therefore changes them only on the falling edge. It places trips at chosen positions within the period (before, exactly at and after the blanking count, and pseudo-randomly). It sweeps feedback in mid-period steps across the linear band and steps it across both burst thresholds, including the threshold codes themselves.

// File: rtl/lfpwm_pkg.sv
package lfpwm_pkg;

  function automatic longint hz_to_step(input longint hz, input int acc_w, input longint clk_hz);
    return (hz * (longint'(1) << acc_w)) / clk_hz;
  endfunction

  function automatic longint time_to_cyc(input longint t, input longint units_per_s,
                                         input longint clk_hz);
    return (t * clk_hz) / units_per_s;
  endfunction

  function automatic longint lin_slope(input longint hi, input longint lo, input longint span,
                                       input int frac);
    return ((hi - lo) * (longint'(1) << frac)) / span;
  endfunction

endpackage

// File: rtl/lfpwm_burst.sv
module lfpwm_burst #(
  parameter int FB_W     = 12,
  parameter int ENTER_MV = 2000,
  parameter int EXIT_MV  = 2100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [FB_W-1:0] fb_mv_i,
  output logic            burst_o
);

  logic below, above;

  assign below = 32'(fb_mv_i) < 32'(ENTER_MV);
  assign above = 32'(fb_mv_i) > 32'(EXIT_MV);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    burst_o <= 1'b0;
    else if (below) burst_o <= 1'b1;
    else if (above) burst_o <= 1'b0;
  end

  AST_BURST_ENTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    below |=> burst_o); // R4
  AST_BURST_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    above |=> !burst_o); // R4
  AST_BURST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!below && !above) |=> $stable(burst_o)); // R4

endmodule

// File: rtl/lfpwm_hop.sv
module lfpwm_hop #(
  parameter int TRI_BITS = 5,
  parameter int STEP_CYC = 15625,
  localparam int TW = TRI_BITS + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  output logic signed [TW-1:0] tri_o
);

  localparam int T_MAX = 1 << TRI_BITS;
  localparam int SW    = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic signed [TW-1:0] T_TURN_UP = TW'(T_MAX - 1);
  localparam logic signed [TW-1:0] T_TURN_DN = TW'(1 - T_MAX);
  localparam logic signed [TW-1:0] T_POS     = TW'(T_MAX);
  localparam logic signed [TW-1:0] T_NEG     = TW'(-T_MAX);
  localparam logic [SW-1:0]        DIV_LAST  = SW'(STEP_CYC - 1);

  logic [SW-1:0] div_q;
  logic          up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      up_q  <= 1'b1;
      tri_o <= '0;
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
      if (up_q) begin
        tri_o <= tri_o + TW'(1);
        if (tri_o == T_TURN_UP) up_q <= 1'b0;
      end else begin
        tri_o <= tri_o - TW'(1);
        if (tri_o == T_TURN_DN) up_q <= 1'b1;
      end
    end else begin
      div_q <= div_q + SW'(1);
    end
  end

  AST_TRI_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tri_o <= T_POS) && (tri_o >= T_NEG)); // R6
  AST_TRI_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (tri_o == $past(tri_o)) || (tri_o == $past(tri_o) + TW'(1))
             || (tri_o == $past(tri_o) - TW'(1))); // R6

endmodule

// File: rtl/lfpwm_map.sv
module lfpwm_map #(
  parameter int FB_W     = 12,
  parameter int ACC_W    = 24,
  parameter int TRI_BITS = 5,
  parameter int FB_HI_MV = 2700,
  parameter int FB_LO_MV = 2250,
  parameter int STEP_HI  = 10905,
  parameter int STEP_LO  = 4026,
  parameter int DEV_HI   = 671,
  parameter int DEV_LO   = 260,
  parameter int FRAC     = 12,
  localparam int TW = TRI_BITS + 2
) (
  input  logic [FB_W-1:0]       fb_mv_i,
  input  logic signed [TW-1:0]  tri_i,
  output logic [ACC_W-1:0]      step_o
);

  localparam int SPAN    = FB_HI_MV - FB_LO_MV;
  localparam int SL_BASE = int'(lfpwm_pkg::lin_slope(STEP_HI, STEP_LO, SPAN, FRAC));
  localparam int SL_DEV  = int'(lfpwm_pkg::lin_slope(DEV_HI, DEV_LO, SPAN, FRAC));
  localparam int STEP_MIN = STEP_LO - DEV_LO;
  localparam int STEP_MAX = STEP_HI + DEV_HI;

  int fb_v, d, base, dev, off, sum;

  always_comb begin
    fb_v = 32'(fb_mv_i);
    d    = 0;
    if (fb_v >= FB_HI_MV) begin
      base = STEP_HI;
      dev  = DEV_HI;
    end else if (fb_v <= FB_LO_MV) begin
      base = STEP_LO;
      dev  = DEV_LO;
    end else begin
      d    = fb_v - FB_LO_MV;
      base = STEP_LO + ((d * SL_BASE) >>> FRAC);
      dev  = DEV_LO + ((d * SL_DEV) >>> FRAC);
    end
    off    = (dev * int'(tri_i)) >>> TRI_BITS;
    sum    = base + off;
    step_o = ACC_W'(sum);
    AST_STEP_RANGE: assert (sum >= STEP_MIN && sum <= STEP_MAX); // R3
  end

endmodule

// File: rtl/lfpwm_core.sv
module lfpwm_core #(
  parameter int ACC_W   = 24,
  parameter int DUTY_TH = 14260633,
  parameter int LEB_CYC = 27
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             trip_i,
  input  logic             skip_req_i,
  input  logic [ACC_W-1:0] step_i,
  output logic             gate_o,
  output logic [ACC_W-1:0] period_o
);

  logic [ACC_W-1:0] acc_q, step_q, pos_q;
  logic [ACC_W:0]   sum;
  logic             run_q, cut_q, skip_q, wrap, leb_done, live;

  assign sum      = {1'b0, acc_q} + {1'b0, step_q};
  assign wrap     = sum[ACC_W];
  assign leb_done = 32'(pos_q) >= 32'(LEB_CYC);
  assign live     = en_i && run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      step_q   <= '0;
      pos_q    <= '0;
      period_o <= '0;
      run_q    <= 1'b0;
      cut_q    <= 1'b0;
      skip_q   <= 1'b0;
    end else if (!live) begin
      // idle or first enabled cycle: load fresh controls
      acc_q  <= '0;
      pos_q  <= '0;
      cut_q  <= 1'b0;
      step_q <= step_i;
      skip_q <= skip_req_i;
      run_q  <= en_i;
    end else begin
      acc_q <= sum[ACC_W-1:0];
      if (wrap) begin
        step_q   <= step_i;
        skip_q   <= skip_req_i;
        cut_q    <= 1'b0;
        period_o <= pos_q + ACC_W'(1);
        pos_q    <= '0;
      end else begin
        pos_q <= pos_q + ACC_W'(1);
        if (trip_i && leb_done) cut_q <= 1'b1;
      end
    end
  end

  assign gate_o = run_q && !skip_q && !cut_q && (32'(acc_q) < 32'(DUTY_TH));

  AST_OFF_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && wrap) |-> !gate_o); // R7
  AST_LEB_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !wrap && !leb_done && !cut_q) |=> !cut_q); // R8
  AST_CUT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && cut_q && !wrap) |=> !gate_o); // R9
  AST_STEP_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !wrap) |=> $stable(step_q)); // R10
  AST_DIS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !gate_o); // R11

endmodule

// File: rtl/lf_pwm_ctrl.sv
module lf_pwm_ctrl #(
  parameter int FB_W           = 12,
  parameter int ACC_W          = 24,
  parameter int CLK_HZ         = 100_000_000,
  parameter int F_HI_HZ        = 65_000,
  parameter int F_LO_HZ        = 24_000,
  parameter int DEV_HI_HZ      = 4_000,
  parameter int DEV_LO_HZ      = 1_550,
  parameter int FB_HI_MV       = 2700,
  parameter int FB_LO_MV       = 2250,
  parameter int BURST_ENTER_MV = 2000,
  parameter int BURST_EXIT_MV  = 2100,
  parameter int DUTY_PCT       = 85,
  parameter int LEB_NS         = 270,
  parameter int HOP_PERIOD_US  = 20_000,
  parameter int TRI_BITS       = 5,
  parameter int FRAC           = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [FB_W-1:0]  fb_mv_i,
  input  logic             cs_trip_i,
  output logic             gate_o,
  output logic             burst_o,
  output logic [ACC_W-1:0] period_o
);

  localparam int TW       = TRI_BITS + 2;
  localparam int STEP_HI  = int'(lfpwm_pkg::hz_to_step(F_HI_HZ, ACC_W, CLK_HZ));
  localparam int STEP_LO  = int'(lfpwm_pkg::hz_to_step(F_LO_HZ, ACC_W, CLK_HZ));
  localparam int DEV_HI   = int'(lfpwm_pkg::hz_to_step(DEV_HI_HZ, ACC_W, CLK_HZ));
  localparam int DEV_LO   = int'(lfpwm_pkg::hz_to_step(DEV_LO_HZ, ACC_W, CLK_HZ));
  localparam int LEB_CYC  = int'(lfpwm_pkg::time_to_cyc(LEB_NS, 1_000_000_000, CLK_HZ));
  localparam int HOP_CYC  = int'(lfpwm_pkg::time_to_cyc(HOP_PERIOD_US, 1_000_000, CLK_HZ));
  localparam int STEP_CYC = (HOP_CYC / (4 << TRI_BITS) > 0) ? HOP_CYC / (4 << TRI_BITS) : 1;
  localparam int DUTY_TH  = int'((longint'(1) << ACC_W) * DUTY_PCT / 100);

  logic signed [TW-1:0] tri_pos;
  logic [ACC_W-1:0]     step_new;

  lfpwm_burst #(
    .FB_W(FB_W), .ENTER_MV(BURST_ENTER_MV), .EXIT_MV(BURST_EXIT_MV)
  ) u_burst (
    .clk_i(clk_i), .rst_ni(rst_ni), .fb_mv_i(fb_mv_i), .burst_o(burst_o)
  );

  lfpwm_hop #(
    .TRI_BITS(TRI_BITS), .STEP_CYC(STEP_CYC)
  ) u_hop (
    .clk_i(clk_i), .rst_ni(rst_ni), .tri_o(tri_pos)
  );

  lfpwm_map #(
    .FB_W(FB_W), .ACC_W(ACC_W), .TRI_BITS(TRI_BITS),
    .FB_HI_MV(FB_HI_MV), .FB_LO_MV(FB_LO_MV),
    .STEP_HI(STEP_HI), .STEP_LO(STEP_LO), .DEV_HI(DEV_HI), .DEV_LO(DEV_LO), .FRAC(FRAC)
  ) u_map (
    .fb_mv_i(fb_mv_i), .tri_i(tri_pos), .step_o(step_new)
  );

  lfpwm_core #(
    .ACC_W(ACC_W), .DUTY_TH(DUTY_TH), .LEB_CYC(LEB_CYC)
  ) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .trip_i(cs_trip_i),
    .skip_req_i(burst_o), .step_i(step_new), .gate_o(gate_o), .period_o(period_o)
  );

endmodule

// File: tb/tb_lf_pwm_ctrl.sv
module tb_lf_pwm_ctrl;

  localparam int  FB_W   = 12;
  localparam int  ACC_W  = 16;
  localparam int  CLK_HZ = 2_600_000;
  localparam int  TBITS  = 3;
  localparam int  LEB_NS = 2000;
  localparam longint FULL   = longint'(1) << ACC_W;
  localparam longint S_HI   = 65000 * FULL / CLK_HZ;
  localparam longint S_LO   = 24000 * FULL / CLK_HZ;
  localparam longint D_HI   = 4000 * FULL / CLK_HZ;
  localparam longint D_LO   = 1550 * FULL / CLK_HZ;
  localparam longint SLB    = ((S_HI - S_LO) * 4096) / 450;
  localparam longint SLH    = ((D_HI - D_LO) * 4096) / 450;
  localparam longint E_LEB  = longint'(LEB_NS) * CLK_HZ / 1_000_000_000;
  localparam longint E_STEP = (longint'(20_000) * CLK_HZ / 1_000_000) / (4 << TBITS);
  localparam longint E_TH   = FULL * 85 / 100;
  localparam int     TMAX   = 1 << TBITS;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, trip = 1'b0;
  logic [FB_W-1:0] fb = 12'd3000;
  logic gate, burst;
  logic [ACC_W-1:0] period;

  always #10 clk = ~clk;

  lf_pwm_ctrl #(
    .FB_W(FB_W), .ACC_W(ACC_W), .CLK_HZ(CLK_HZ), .LEB_NS(LEB_NS), .TRI_BITS(TBITS)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .fb_mv_i(fb), .cs_trip_i(trip),
    .gate_o(gate), .burst_o(burst), .period_o(period)
  );

  int checks = 0, errors = 0;
  string req = "R11";
  bit mon_on = 1'b0, done = 1'b0;

  task automatic chk(input string r, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", r, what, act, exp, $time);
    end
  endtask

  // behavioural reference
  longint m_acc, m_step, m_pos, m_per;
  int m_t, m_div;
  bit m_up, m_run, m_cut, m_skip, m_burst;

  function automatic longint want_step(input int f, input int t);
    longint b, d;
    if (f >= 2700) begin b = S_HI; d = D_HI; end
    else if (f <= 2250) begin b = S_LO; d = D_LO; end
    else begin
      b = S_LO + (((f - 2250) * SLB) >>> 12);
      d = D_LO + (((f - 2250) * SLH) >>> 12);
    end
    return b + ((d * t) >>> TBITS);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_step = 0; m_pos = 0; m_per = 0; m_t = 0; m_div = 0;
      m_up = 1; m_run = 0; m_cut = 0; m_skip = 0; m_burst = 0;
    end else begin
      longint nstep, s;
      nstep = want_step(int'(fb), m_t);
      if (m_div == E_STEP - 1) begin
        m_div = 0;
        if (m_up) begin m_t++; if (m_t == TMAX) m_up = 0; end
        else begin m_t--; if (m_t == -TMAX) m_up = 1; end
      end else m_div++;
      if (!en || !m_run) begin
        m_acc = 0; m_pos = 0; m_cut = 0; m_step = nstep; m_skip = m_burst; m_run = en;
      end else begin
        s = m_acc + m_step;
        if (s >= FULL) begin
          m_acc = s - FULL; m_step = nstep; m_skip = m_burst; m_cut = 0;
          m_per = m_pos + 1; m_pos = 0;
        end else begin
          m_acc = s;
          if (trip && m_pos >= E_LEB) m_cut = 1;
          m_pos++;
        end
      end
      if (fb < 2000) m_burst = 1;
      else if (fb > 2100) m_burst = 0;
    end
  end

  always @(negedge clk) if (mon_on && !done) begin
    chk(req, "gate", longint'(gate), longint'(m_run && !m_skip && !m_cut && m_acc < E_TH));
    chk(req, "burst", longint'(burst), longint'(m_burst));
    chk(req, "period", longint'(period), m_per);
  end

  task automatic run(input string r, input int f, input int n);
    req = r;
    fb = FB_W'(f);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 190_000);
    errors++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11", "reset gate", longint'(gate), 0);
    chk("R4", "reset burst", longint'(burst), 0);
    chk("R12", "reset period", longint'(period), 0);
    mon_on = 1'b1;
    en = 1'b1;
    run("R1", 3000, 3000);
    run("R12", 2800, 1500);
    run("R3", 2400, 3000);
    run("R2", 2200, 3000);
    run("R7", 2300, 1500);
    req = "R10";
    for (int i = 0; i < 200; i++) begin
      fb = FB_W'(2250 + (i * 37) % 451);
      repeat (23) @(negedge clk);
    end
    run("R6", 3000, 16000);
    run("R6", 2500, 16000);
    run("R4", 2050, 500);
    run("R4", 2000, 500);
    run("R4", 1990, 300);
    run("R5", 2050, 1000);
    run("R5", 2100, 500);
    run("R4", 2101, 300);
    run("R5", 2150, 800);
    run("R5", 1500, 600);
    run("R5", 2700, 800);
    req = "R8";
    repeat (1500) begin @(negedge clk); trip = (m_pos == 2) || (m_pos == E_LEB - 1); end
    req = "R9";
    repeat (1500) begin @(negedge clk); trip = (m_pos == E_LEB); end
    repeat (1500) begin @(negedge clk); trip = ((m_pos % 7) == 5); end
    begin
      int lf = 32'h1ace;
      repeat (2000) begin
        @(negedge clk);
        lf = (lf >> 1) ^ ((lf & 1) != 0 ? 32'h0000b400 : 0);
        trip = (lf & 7) == 0;
      end
    end
    trip = 1'b0;
    req = "R11";
    en = 1'b0;
    repeat (200) @(negedge clk);
    en = 1'b1;
    repeat (300) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    run("R12", 2600, 2000);
    run("R1", 4000, 1000);
    finish_up();
  end

endmodule